// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central hazard keeper for a small pipeline that issues instructions in program order and lets them complete out of order across four functional units. The units are integer/load, multiply, add/subtract and divide. Each cycle it may accept one decoded instruction, given as a unit class, an operation code, a destination register and two source registers. It then grants three things: issue into the chosen unit, operand read for each unit, and result write-back for each unit. The units report the end of execution with a one-cycle completion pulse.

The block keeps a status entry per unit and a pending-write record per register. It never renames registers and never forwards values. Each hazard is resolved by waiting at its own stage. Structural and write-after-write hazards hold issue. Read-after-write hazards hold the operand read of the waiting unit. Write-after-read hazards hold the write-back of the finished unit. A unit that is waiting does not delay the read or write-back of any other unit. Arithmetic, memory access and the register file itself sit outside the block.

Top module: `sb_hazard_ctrl`

## Requirements
- R1: After reset no unit is busy, and no operand read or write-back grant is asserted.
- R2: `issue_ok` is high exactly when `dec_valid` is high, the unit selected by `dec_unit` is idle, and no in-flight instruction has `dec_dst` pending for write. The unit encoding is 0 integer/load, 1 multiply, 2 add/subtract, 3 divide.
- R3: A unit granted write-back in cycle t is still refused issue in cycle t and can accept a new instruction from cycle t+1.
- R4: `rd_go` for a unit is high only while it waits for operands and both of its sources have no pending write. Because there is no forwarding, this happens no earlier than the cycle after the producer's write-back. Each issued instruction is granted exactly one read.
- R5: `unit_busy` stays high from the cycle after issue until the cycle after write-back. A completion pulse is accepted only while the unit is executing. A pulse at any other time has no effect.
- R6: A finished unit is not granted write-back while another unit still waits to read a source that equals its destination and that source is already marked available.
- R7: At most one `wb_go` bit is high per cycle. Among the eligible units, the lowest unit index wins.
- R8: During write-back, `wb_reg` and `wb_op` show the destination and operation code of the granted unit, and that destination's pending write is released.
- R9: A unit that is stalled on read or write-back does not hold the operand read of any other unit.
- R10: A source is marked available at issue if it has no pending write, or if its producer is writing back in that same cycle. A source that equals the instruction's own destination counts as the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decoded instruction present |
| dec_unit | input | 2 | Target unit class |
| dec_op | input | OP_W | Operation code stored with the instruction |
| dec_dst | input | REG_W | Destination register |
| dec_src1 | input | REG_W | First source register |
| dec_src2 | input | REG_W | Second source register |
| exec_done | input | 4 | Per-unit completion pulse |
| issue_ok | output | 1 | Instruction accepted this cycle |
| rd_go | output | 4 | Per-unit operand read grant |
| wb_go | output | 4 | Per-unit write-back grant |
| wb_reg | output | REG_W | Destination being written |
| wb_op | output | OP_W | Operation code of the writing unit |
| unit_busy | output | 4 | Per-unit occupancy |

## Verification
The bench first drives a fixed six-instruction sequence that contains two loads to the same unit, two consumers waiting on one load, a long divide waiting on a multiply, and a later add that overwrites a divide source. This one sequence separates a structural stall, a read-after-write stall and a write-after-read stall from one another. Directed cases follow. One issues back-to-back instructions to the same unit, which exposes the cycle after a unit is freed. One uses an instruction whose sources equal its own destination. One injects spurious completion pulses into units that are idle or still waiting. Constrained random traffic over eight registers then packs same-cycle write-back contention, issue coinciding with a producer's write-back, and multi-unit waits far more densely than any directed case can.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int UNITS  = 4;
  localparam int UNIT_W = 2;

  typedef enum logic [1:0] {
    PH_IDLE     = 2'd0,
    PH_WAIT_OPS = 2'd1,
    PH_EXEC     = 2'd2,
    PH_WAIT_WB  = 2'd3
  } phase_t;
endpackage

// File: rtl/sb_unit_entry.sv
module sb_unit_entry
  import sb_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int OP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [OP_W-1:0]   ld_op,
  input  logic [REG_W-1:0]  ld_dst,
  input  logic [REG_W-1:0]  ld_src1,
  input  logic [REG_W-1:0]  ld_src2,
  input  logic              ld_rdy1,
  input  logic              ld_rdy2,
  input  logic              ld_tag1_vld,
  input  logic              ld_tag2_vld,
  input  logic [UNIT_W-1:0] ld_tag1,
  input  logic [UNIT_W-1:0] ld_tag2,
  input  logic              bcast_vld,
  input  logic [UNIT_W-1:0] bcast_unit,
  input  logic              self_wb,
  input  logic              done_in,
  output phase_t            phase,
  output logic [OP_W-1:0]   op,
  output logic [REG_W-1:0]  dst,
  output logic [REG_W-1:0]  src1,
  output logic [REG_W-1:0]  src2,
  output logic              rdy1,
  output logic              rdy2,
  output logic              rd_req,
  output logic              wb_pend
);

  phase_t              phase_q, phase_d;
  logic                rdy1_q, rdy1_d, rdy2_q, rdy2_d;
  logic                t1v_q, t1v_d, t2v_q, t2v_d;
  logic [UNIT_W-1:0]   t1_q, t1_d, t2_q, t2_d;
  logic [OP_W-1:0]     op_q;
  logic [REG_W-1:0]    dst_q, s1_q, s2_q;

  assign rd_req  = (phase_q == PH_WAIT_OPS) && rdy1_q && rdy2_q;
  assign wb_pend = (phase_q == PH_WAIT_WB);

  always_comb begin
    phase_d = phase_q;
    rdy1_d  = rdy1_q;
    rdy2_d  = rdy2_q;
    t1v_d   = t1v_q;
    t2v_d   = t2v_q;
    t1_d    = t1_q;
    t2_d    = t2_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (load) begin
          phase_d = PH_WAIT_OPS;
          rdy1_d  = ld_rdy1;
          rdy2_d  = ld_rdy2;
          t1v_d   = ld_tag1_vld;
          t2v_d   = ld_tag2_vld;
          t1_d    = ld_tag1;
          t2_d    = ld_tag2;
        end
      end
      PH_WAIT_OPS: begin
        if (bcast_vld && t1v_q && (t1_q == bcast_unit)) begin
          rdy1_d = 1'b1;
          t1v_d  = 1'b0;
        end
        if (bcast_vld && t2v_q && (t2_q == bcast_unit)) begin
          rdy2_d = 1'b1;
          t2v_d  = 1'b0;
        end
        if (rd_req) begin
          phase_d = PH_EXEC;
          rdy1_d  = 1'b0;
          rdy2_d  = 1'b0;
        end
      end
      PH_EXEC: begin
        if (done_in) phase_d = PH_WAIT_WB;
      end
      PH_WAIT_WB: begin
        if (self_wb) phase_d = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      rdy1_q  <= 1'b0;
      rdy2_q  <= 1'b0;
      t1v_q   <= 1'b0;
      t2v_q   <= 1'b0;
      t1_q    <= '0;
      t2_q    <= '0;
      op_q    <= '0;
      dst_q   <= '0;
      s1_q    <= '0;
      s2_q    <= '0;
    end else begin
      phase_q <= phase_d;
      rdy1_q  <= rdy1_d;
      rdy2_q  <= rdy2_d;
      t1v_q   <= t1v_d;
      t2v_q   <= t2v_d;
      t1_q    <= t1_d;
      t2_q    <= t2_d;
      if (load) begin
        op_q  <= ld_op;
        dst_q <= ld_dst;
        s1_q  <= ld_src1;
        s2_q  <= ld_src2;
      end
    end
  end

  assign phase = phase_q;
  assign op    = op_q;
  assign dst   = dst_q;
  assign src1  = s1_q;
  assign src2  = s2_q;
  assign rdy1  = rdy1_q;
  assign rdy2  = rdy2_q;

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && !self_wb) |=> (phase_q != PH_IDLE));

  // R4
  cleared_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_EXEC) |-> (!rdy1_q && !rdy2_q));

endmodule

// File: rtl/sb_reg_table.sv
module sb_reg_table #(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = 5,
  parameter int UNIT_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [REG_W-1:0]  set_reg,
  input  logic [UNIT_W-1:0] set_unit,
  input  logic              clr_en,
  input  logic [REG_W-1:0]  clr_reg,
  input  logic [REG_W-1:0]  q_dst,
  input  logic [REG_W-1:0]  q_src1,
  input  logic [REG_W-1:0]  q_src2,
  output logic              res_dst,
  output logic              res_src1,
  output logic              res_src2,
  output logic [UNIT_W-1:0] prod_src1,
  output logic [UNIT_W-1:0] prod_src2
);

  logic [NUM_REGS-1:0] res_vec;
  logic [UNIT_W-1:0]   prod_arr [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic              set_hit, clr_hit;
    logic              res_q, res_d;
    logic [UNIT_W-1:0] prod_q;

    assign set_hit = set_en && (set_reg == REG_W'(r));
    assign clr_hit = clr_en && (clr_reg == REG_W'(r));

    always_comb begin
      res_d = res_q;
      if (set_hit)      res_d = 1'b1;
      else if (clr_hit) res_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q  <= 1'b0;
        prod_q <= '0;
      end else begin
        res_q <= res_d;
        if (set_hit) prod_q <= set_unit;
      end
    end

    assign res_vec[r]  = res_q;
    assign prod_arr[r] = prod_q;
  end

  assign res_dst   = res_vec[q_dst];
  assign res_src1  = res_vec[q_src1];
  assign res_src2  = res_vec[q_src2];
  assign prod_src1 = prod_arr[q_src1];
  assign prod_src2 = prod_arr[q_src2];

  // R2
  waw_reserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !res_vec[set_reg]);

  // R8
  release_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> res_vec[clr_reg]);

endmodule

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl
  import sb_pkg::*;
(
  input  logic              dec_valid,
  input  logic [UNIT_W-1:0] dec_unit,
  input  logic [UNITS-1:0]  unit_idle,
  input  logic              res_dst,
  input  logic              res_src1,
  input  logic              res_src2,
  input  logic [UNIT_W-1:0] prod_src1,
  input  logic [UNIT_W-1:0] prod_src2,
  input  logic              wb_fire,
  input  logic [UNIT_W-1:0] wb_unit,
  output logic              issue_ok,
  output logic              rdy1,
  output logic              rdy2,
  output logic              tag1_vld,
  output logic              tag2_vld,
  output logic [UNIT_W-1:0] tag1,
  output logic [UNIT_W-1:0] tag2
);

  always_comb begin
    issue_ok = dec_valid && unit_idle[dec_unit] && !res_dst;
    rdy1     = !res_src1 || (wb_fire && (prod_src1 == wb_unit));
    rdy2     = !res_src2 || (wb_fire && (prod_src2 == wb_unit));
    tag1_vld = !rdy1;
    tag2_vld = !rdy2;
    tag1     = prod_src1;
    tag2     = prod_src2;
  end

endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic             fire,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
      end
    end
    fire = |req;
  end

endmodule

// File: rtl/sb_hazard_ctrl.sv
module sb_hazard_ctrl
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int OP_W     = 4,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  input  logic [UNIT_W-1:0] dec_unit,
  input  logic [OP_W-1:0]   dec_op,
  input  logic [REG_W-1:0]  dec_dst,
  input  logic [REG_W-1:0]  dec_src1,
  input  logic [REG_W-1:0]  dec_src2,
  input  logic [UNITS-1:0]  exec_done,
  output logic              issue_ok,
  output logic [UNITS-1:0]  rd_go,
  output logic [UNITS-1:0]  wb_go,
  output logic [REG_W-1:0]  wb_reg,
  output logic [OP_W-1:0]   wb_op,
  output logic [UNITS-1:0]  unit_busy
);

  phase_t             ph    [UNITS];
  logic [OP_W-1:0]    e_op  [UNITS];
  logic [REG_W-1:0]   e_dst [UNITS];
  logic [REG_W-1:0]   e_s1  [UNITS];
  logic [REG_W-1:0]   e_s2  [UNITS];
  logic [UNITS-1:0]   e_r1, e_r2, rd_req, wb_pend, war_blk, wb_req;
  logic [UNITS-1:0]   unit_idle, load_vec;
  logic               wb_fire;
  logic [UNIT_W-1:0]  wb_idx;
  logic               res_dst, res_s1, res_s2;
  logic [UNIT_W-1:0]  prod_s1, prod_s2;
  logic               n_rdy1, n_rdy2, n_t1v, n_t2v;
  logic [UNIT_W-1:0]  n_t1, n_t2;

  sb_reg_table #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .UNIT_W(UNIT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .set_en(issue_ok), .set_reg(dec_dst), .set_unit(dec_unit),
    .clr_en(wb_fire), .clr_reg(wb_reg),
    .q_dst(dec_dst), .q_src1(dec_src1), .q_src2(dec_src2),
    .res_dst(res_dst), .res_src1(res_s1), .res_src2(res_s2),
    .prod_src1(prod_s1), .prod_src2(prod_s2)
  );

  sb_issue_ctrl u_issue (
    .dec_valid(dec_valid), .dec_unit(dec_unit), .unit_idle(unit_idle),
    .res_dst(res_dst), .res_src1(res_s1), .res_src2(res_s2),
    .prod_src1(prod_s1), .prod_src2(prod_s2),
    .wb_fire(wb_fire), .wb_unit(wb_idx),
    .issue_ok(issue_ok), .rdy1(n_rdy1), .rdy2(n_rdy2),
    .tag1_vld(n_t1v), .tag2_vld(n_t2v), .tag1(n_t1), .tag2(n_t2)
  );

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    assign load_vec[u]  = issue_ok && (dec_unit == UNIT_W'(u));
    assign unit_idle[u] = (ph[u] == PH_IDLE);

    sb_unit_entry #(.REG_W(REG_W), .OP_W(OP_W)) u_entry (
      .clk(clk), .rst_n(rst_n), .load(load_vec[u]),
      .ld_op(dec_op), .ld_dst(dec_dst), .ld_src1(dec_src1), .ld_src2(dec_src2),
      .ld_rdy1(n_rdy1), .ld_rdy2(n_rdy2),
      .ld_tag1_vld(n_t1v), .ld_tag2_vld(n_t2v), .ld_tag1(n_t1), .ld_tag2(n_t2),
      .bcast_vld(wb_fire), .bcast_unit(wb_idx),
      .self_wb(wb_go[u]), .done_in(exec_done[u]),
      .phase(ph[u]), .op(e_op[u]), .dst(e_dst[u]),
      .src1(e_s1[u]), .src2(e_s2[u]), .rdy1(e_r1[u]), .rdy2(e_r2[u]),
      .rd_req(rd_req[u]), .wb_pend(wb_pend[u])
    );
  end

  // write-after-read: a finished unit waits while any other unit still
  // has an unread, available copy of its destination
  always_comb begin
    war_blk = '0;
    for (int u = 0; u < UNITS; u++) begin
      for (int v = 0; v < UNITS; v++) begin
        if ((v != u) && (ph[v] == PH_WAIT_OPS) &&
            (((e_s1[v] == e_dst[u]) && e_r1[v]) ||
             ((e_s2[v] == e_dst[u]) && e_r2[v])))
          war_blk[u] = 1'b1;
      end
    end
  end

  assign wb_req = wb_pend & ~war_blk;

  sb_wb_arb #(.N(UNITS), .IDX_W(UNIT_W)) u_arb (
    .req(wb_req), .grant(wb_go), .fire(wb_fire), .idx(wb_idx)
  );

  assign rd_go     = rd_req;
  assign wb_reg    = e_dst[wb_idx];
  assign wb_op     = e_op[wb_idx];
  assign unit_busy = ~unit_idle;

  // R2
  issue_occupies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ok |=> unit_busy[$past(dec_unit)]);

  // R7
  wb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wb_go));

  for (genvar u = 0; u < UNITS; u++) begin : g_chk
    // R3
    freed_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_go[u] |=> !unit_busy[u]);

    // R4
    single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_go[u] |=> !rd_go[u]);
  end

endmodule

// File: tb/sb_hazard_ctrl_test.sv
`timescale 1ns/1ps
module sb_hazard_ctrl_test;
  localparam int NR = 32;
  localparam int RW = 5;
  localparam int OW = 4;

  logic          clk;
  logic          rst_n;
  logic          dec_valid;
  logic [1:0]    dec_unit;
  logic [OW-1:0] dec_op;
  logic [RW-1:0] dec_dst, dec_src1, dec_src2;
  logic [3:0]    exec_done;
  logic          issue_ok;
  logic [3:0]    rd_go, wb_go, unit_busy;
  logic [RW-1:0] wb_reg;
  logic [OW-1:0] wb_op;

  sb_hazard_ctrl #(.NUM_REGS(NR), .OP_W(OW)) uut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_unit(dec_unit),
    .dec_op(dec_op), .dec_dst(dec_dst), .dec_src1(dec_src1), .dec_src2(dec_src2),
    .exec_done(exec_done), .issue_ok(issue_ok), .rd_go(rd_go), .wb_go(wb_go),
    .wb_reg(wb_reg), .wb_op(wb_op), .unit_busy(unit_busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  // reference model state (phase: 0 idle, 1 wait ops, 2 exec, 3 wait wb)
  int m_ph [4];
  int m_dst [4], m_s1 [4], m_s2 [4], m_op [4], m_lat [4];
  bit m_r1 [4], m_r2 [4], m_t1v [4], m_t2v [4];
  int m_t1 [4], m_t2 [4];
  bit m_res [NR];
  int m_prod [NR];
  logic [3:0] last_rd;

  function automatic int lat_of(int k);
    case (k)
      0: return 1;
      1: return 3;
      2: return 2;
      default: return 5;
    endcase
  endfunction

  function automatic bit war_of(int k);
    for (int v = 0; v < 4; v++)
      if (v != k && m_ph[v] == 1 &&
          ((m_s1[v] == m_dst[k] && m_r1[v]) || (m_s2[v] == m_dst[k] && m_r2[v])))
        return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 4; k++) begin
      m_ph[k] = 0; m_r1[k] = 0; m_r2[k] = 0; m_t1v[k] = 0; m_t2v[k] = 0;
      m_dst[k] = 0; m_s1[k] = 0; m_s2[k] = 0; m_op[k] = 0; m_lat[k] = 0;
      m_t1[k] = 0; m_t2[k] = 0;
    end
    for (int r = 0; r < NR; r++) begin
      m_res[r] = 0; m_prod[r] = 0;
    end
  endtask

  task automatic do_cycle(input bit v, input int u, input int d, input int s1,
                          input int s2, input int op, input logic [3:0] fd,
                          output bit iss);
    bit e_rd [4];
    int win;
    bit e_iss, nr1, nr2, stalled;
    logic [3:0] e_wb, dn;
    @(negedge clk);
    dec_valid = v;
    dec_unit  = 2'(u);
    dec_dst   = RW'(d);
    dec_src1  = RW'(s1);
    dec_src2  = RW'(s2);
    dec_op    = OW'(op);
    for (int k = 0; k < 4; k++)
      dn[k] = (m_ph[k] == 2 && m_lat[k] <= 1) || fd[k];
    exec_done = dn;
    #1;
    win = -1;
    e_wb = '0;
    stalled = 0;
    for (int k = 0; k < 4; k++) begin
      e_rd[k] = (m_ph[k] == 1) && m_r1[k] && m_r2[k];
      if (m_ph[k] == 1 && !(m_r1[k] && m_r2[k])) stalled = 1;
      if (m_ph[k] == 3 && war_of(k)) stalled = 1;
    end
    for (int k = 3; k >= 0; k--)
      if (m_ph[k] == 3 && !war_of(k)) win = k;
    if (win >= 0) e_wb[win] = 1'b1;
    e_iss = v && m_ph[u] == 0 && !m_res[d];
    nr1 = !m_res[s1] || (win >= 0 && m_prod[s1] == win);
    nr2 = !m_res[s2] || (win >= 0 && m_prod[s2] == win);

    // R2 issue decision
    chk(issue_ok == e_iss, "R2 issue", int'(issue_ok), int'(e_iss));
    // R3 unit refused on its own write-back cycle
    if (v && wb_go[u]) chk(!issue_ok, "R3 reissue", int'(issue_ok), 0);
    for (int k = 0; k < 4; k++) begin
      // R4 operand read gating (R10 snapshot shows up here too)
      chk(rd_go[k] == e_rd[k], "R4 R10 read", int'(rd_go[k]), int'(e_rd[k]));
      // R5 occupancy
      chk(unit_busy[k] == (m_ph[k] != 0), "R5 busy", int'(unit_busy[k]), int'(m_ph[k] != 0));
      // R6 write-after-read hold
      if (m_ph[k] == 3 && war_of(k)) chk(!wb_go[k], "R6 war", int'(wb_go[k]), 0);
      // R9 independence from a stalled unit
      if (stalled && e_rd[k]) chk(rd_go[k], "R9 indep", int'(rd_go[k]), 1);
    end
    // R7 single grant with fixed priority
    chk(wb_go == e_wb, "R7 wb", int'(wb_go), int'(e_wb));
    if (win >= 0) begin
      // R8 written destination and op
      chk(wb_reg == RW'(m_dst[win]), "R8 reg", int'(wb_reg), m_dst[win]);
      chk(wb_op == OW'(m_op[win]), "R8 op", int'(wb_op), m_op[win]);
    end
    last_rd = rd_go;
    iss = e_iss;

    @(posedge clk);
    if (win >= 0) begin
      for (int k = 0; k < 4; k++) begin
        if (m_ph[k] == 1) begin
          if (m_t1v[k] && m_t1[k] == win) begin m_r1[k] = 1; m_t1v[k] = 0; end
          if (m_t2v[k] && m_t2[k] == win) begin m_r2[k] = 1; m_t2v[k] = 0; end
        end
      end
      m_ph[win] = 0;
      m_res[m_dst[win]] = 0;
    end
    for (int k = 0; k < 4; k++)
      if (m_ph[k] == 2) begin
        if (dn[k]) m_ph[k] = 3;
        else m_lat[k] = m_lat[k] - 1;
      end
    for (int k = 0; k < 4; k++)
      if (e_rd[k]) begin
        m_ph[k] = 2; m_r1[k] = 0; m_r2[k] = 0; m_lat[k] = lat_of(k);
      end
    if (e_iss) begin
      m_ph[u] = 1; m_dst[u] = d; m_s1[u] = s1; m_s2[u] = s2; m_op[u] = op & 15;
      m_r1[u] = nr1; m_r2[u] = nr2;
      m_t1v[u] = !nr1; m_t2v[u] = !nr2;
      m_t1[u] = m_prod[s1]; m_t2[u] = m_prod[s2];
      m_res[d] = 1; m_prod[d] = u;
    end
  endtask

  task automatic push(input int u, input int d, input int s1, input int s2);
    bit iss;
    int tries;
    iss = 0;
    tries = 0;
    while (!iss && tries < 300) begin
      do_cycle(1, u, d, s1, s2, d + u, 4'b0000, iss);
      tries++;
    end
    if (!iss) chk(0, "R2 push timeout", 0, 1);
  endtask

  task automatic idle(input int n);
    bit iss;
    for (int i = 0; i < n; i++) do_cycle(0, 0, 0, 0, 0, 0, 4'b0000, iss);
  endtask

  initial begin
    #(8 * 150000);
    if (!done_flag) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit iss;
    bit pv;
    int pu, pd, ps1, ps2, pop;
    logic [3:0] fd;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    dec_valid = 0; dec_unit = 0; dec_op = 0; dec_dst = 0; dec_src1 = 0; dec_src2 = 0;
    exec_done = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(unit_busy == 4'b0, "R1 busy", int'(unit_busy), 0);
    chk(rd_go == 4'b0, "R1 read", int'(rd_go), 0);
    chk(wb_go == 4'b0, "R1 wb", int'(wb_go), 0);
    rst_n = 1'b1;

    // mixed-hazard sequence: loads, mul, sub, div, add overwriting a div source
    push(0, 6, 20, 21);
    push(0, 2, 22, 23);
    push(1, 1, 2, 4);
    push(2, 8, 6, 2);
    push(3, 10, 1, 6);
    push(2, 6, 8, 2);
    // R5 spurious completion pulses to all units
    do_cycle(0, 0, 0, 0, 0, 0, 4'b1111, iss);
    idle(30);

    // R3 back-to-back use of one unit
    push(0, 11, 12, 13);
    push(0, 14, 11, 13);
    push(0, 15, 14, 11);
    idle(10);

    // R10 sources equal to own destination read at once
    push(2, 5, 5, 5);
    do_cycle(0, 0, 0, 0, 0, 0, 4'b0000, iss);
    chk(last_rd[2] == 1'b1, "R10 self source", int'(last_rd[2]), 1);
    idle(10);

    // R5 done while waiting for operands is ignored
    push(1, 7, 3, 3);
    push(3, 9, 7, 7);
    do_cycle(0, 0, 0, 0, 0, 0, 4'b1000, iss);
    chk(unit_busy[3] == 1'b1, "R5 ignored done", int'(unit_busy[3]), 1);
    idle(20);

    // constrained random traffic over eight registers
    pv = 0; pu = 0; pd = 0; ps1 = 0; ps2 = 0; pop = 0;
    for (int c = 0; c < 5000; c++) begin
      if (!pv && ($urandom % 10) < 7) begin
        pv = 1;
        pu = $urandom % 4; pd = $urandom % 8;
        ps1 = $urandom % 8; ps2 = $urandom % 8; pop = $urandom % 16;
      end
      fd = (($urandom % 25) == 0) ? 4'($urandom) : 4'b0000;
      do_cycle(pv, pu, pd, ps1, ps2, pop, fd, iss);
      if (iss) pv = 0;
    end
    idle(40);
    chk(unit_busy == 4'b0, "R5 drained", int'(unit_busy), 0);

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule